// File: doc/BRIEF.md
# Event-Triggered Register Write Sequencer

This block replays a list of register writes held in memory onto a register write port. Each list entry takes two 32-bit words. The first word is the address of the target register and the second word is the value to write there. Software sets a first-byte pointer and an inclusive last-byte pointer for the list. It then picks a trigger source and an address mode in a mode register.

A trigger can be a vertical-sync pulse, a line-counter pulse, or a manual kick. When the selected trigger fires, the engine reads the list in ascending address order through a valid/ready memory read port that returns data with a response-valid strobe. It issues one register write per entry. When the last write is accepted, the engine raises a sticky done flag and a level interrupt. The channel stays armed and replays the whole list on every later event until software writes the stop code.

A malformed list, or a mode with the write direction cleared, raises an error flag and produces no writes. A self-clearing soft reset returns the engine to idle, disarms it and clears its status.

Top module: `evt_regwr_seq`

## Requirements
- R1: After reset, `irq`, `mem_req_valid` and `reg_wr_valid` are low. The status word (config index 4) and the mode word (index 3) read zero.
- R2: A list entry is the address word at byte offset 0 followed by the data word at offset 4. Entries are fetched from the first-byte pointer (index 1) upward. Exactly one register write is issued per entry, in list order.
- R3: A pass ends with the entry whose data word ends at the last-byte pointer (index 2, equal to first + 8·n − 1). After the last write is accepted, status bit 1 (done) and `irq` are set. Status bit 0 (busy) is high while a pass runs.
- R4: Mode bits [1:0] select the trigger: 0 stop, 1 vertical-sync pulse `vsync_evt`, 2 line pulse `line_evt`, 3 manual. A mode write carrying code 3 starts one pass at once. A pulse on the unselected event input starts nothing.
- R5: Trigger events that arrive while a pass is busy are ignored. After a pass completes, the channel stays armed, and the next selected event starts another full pass.
- R6: A mode write with trigger code 0 during a pass lets the register write in progress complete. After that, no further memory request is made and done is not set.
- R7: Mode bit 5 (increment) cleared: each write goes to its entry's address word. Set: entry k (from 0) goes to its address word + 4·k.
- R8: If the last pointer is below the first pointer, or the list length (last − first + 1) is not a multiple of 8, or mode bit 4 (write direction) is 0, a trigger sets status bit 2 (error) and `irq` and performs no memory request or write.
- R9: Writing control (index 0) with bit 1 set clears done and error, and `irq` falls.
- R10: Writing control with bit 0 set idles the engine, clears done and error, and resets the trigger field to stop. The bit reads back as 0.
- R11: While `reg_wr_ready` is low, the register write holds its address and data. While `mem_req_ready` is low, the memory request holds its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` (combinational) |
| vsync_evt | input | 1 | Vertical-sync event pulse |
| line_evt | input | 1 | Line-counter event pulse |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory read request accepted |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register write accepted |
| reg_wr_addr | output | 32 | Target register address |
| reg_wr_data | output | 32 | Value to write |
| irq | output | 1 | Level interrupt: done or error |

## Verification
A register write is compared as soon as its handshake is visible, at the falling edge before the accepting clock. The interrupt is due one clock after the event that causes it: the last accepted write, a trigger on a bad list, or a clear or soft-reset write. The bench's model therefore updates its expected interrupt only after each falling-edge comparison, so the new value is checked in the next cycle. Status and mode reads are taken half a clock after the edge that updated them. A pass is started by the kick's edge, so the busy bit polled afterwards is already high.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [1:0] {
    TRG_STOP   = 2'd0,
    TRG_VSYNC  = 2'd1,
    TRG_LINE   = 2'd2,
    TRG_MANUAL = 2'd3
  } trig_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ_A,
    S_WAIT_A,
    S_REQ_D,
    S_WAIT_D,
    S_WRITE
  } state_e;

  localparam logic [2:0] IDX_CTRL   = 3'd0;
  localparam logic [2:0] IDX_BEGIN  = 3'd1;
  localparam logic [2:0] IDX_LAST   = 3'd2;
  localparam logic [2:0] IDX_MODE   = 3'd3;
  localparam logic [2:0] IDX_STATUS = 3'd4;

  localparam int CTRL_SRST_BIT = 0;
  localparam int CTRL_CLR_BIT  = 1;
  localparam int MODE_WDIR_BIT = 4;
  localparam int MODE_INC_BIT  = 5;
endpackage

// File: rtl/seq_csr.sv
module seq_csr
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          busy,
  input  logic          done,
  input  logic          err,
  output logic [AW-1:0] list_begin,
  output logic [AW-1:0] list_last,
  output trig_e         trig,
  output logic          wflag,
  output logic          inc,
  output logic          soft_rst,
  output logic          clr_stat,
  output logic          manual_kick,
  output logic          stop_req
);
  logic [AW-1:0] begin_q, begin_n, last_q, last_n;
  trig_e         trig_q, trig_n, new_trig;
  logic          wflag_q, wflag_n, inc_q, inc_n;
  logic          wr_ctrl, wr_begin, wr_last, wr_mode;

  assign wr_ctrl  = cfg_we && (cfg_addr == IDX_CTRL);
  assign wr_begin = cfg_we && (cfg_addr == IDX_BEGIN);
  assign wr_last  = cfg_we && (cfg_addr == IDX_LAST);
  assign wr_mode  = cfg_we && (cfg_addr == IDX_MODE);
  assign new_trig = trig_e'(cfg_wdata[1:0]);

  assign soft_rst    = wr_ctrl && cfg_wdata[CTRL_SRST_BIT];
  assign clr_stat    = wr_ctrl && cfg_wdata[CTRL_CLR_BIT];
  assign manual_kick = wr_mode && (new_trig == TRG_MANUAL);
  assign stop_req    = wr_mode && (new_trig == TRG_STOP);

  always_comb begin
    begin_n = begin_q;
    last_n  = last_q;
    trig_n  = trig_q;
    wflag_n = wflag_q;
    inc_n   = inc_q;
    if (wr_begin) begin_n = cfg_wdata[AW-1:0];
    if (wr_last)  last_n  = cfg_wdata[AW-1:0];
    if (soft_rst) begin
      trig_n = TRG_STOP;
    end else if (wr_mode) begin
      trig_n  = new_trig;
      wflag_n = cfg_wdata[MODE_WDIR_BIT];
      inc_n   = cfg_wdata[MODE_INC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      begin_q <= '0;
      last_q  <= '0;
      trig_q  <= TRG_STOP;
      wflag_q <= 1'b0;
      inc_q   <= 1'b0;
    end else begin
      begin_q <= begin_n;
      last_q  <= last_n;
      trig_q  <= trig_n;
      wflag_q <= wflag_n;
      inc_q   <= inc_n;
    end
  end

  // A mode write that kicks a pass must see its own direction and increment bits.
  assign list_begin = begin_q;
  assign list_last  = last_q;
  assign trig       = trig_q;
  assign wflag      = wr_mode ? cfg_wdata[MODE_WDIR_BIT] : wflag_q;
  assign inc        = wr_mode ? cfg_wdata[MODE_INC_BIT] : inc_q;

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      IDX_BEGIN:  cfg_rdata = DW'(begin_q);
      IDX_LAST:   cfg_rdata = DW'(last_q);
      IDX_MODE: begin
        cfg_rdata[1:0]           = trig_q;
        cfg_rdata[MODE_WDIR_BIT] = wflag_q;
        cfg_rdata[MODE_INC_BIT]  = inc_q;
      end
      IDX_STATUS: cfg_rdata[2:0] = {err, done, busy};
      default:    cfg_rdata = '0;
    endcase
  end

  AST_SRST_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> trig_q == TRG_STOP); // R10
endmodule

// File: rtl/seq_trig.sv
module seq_trig
  import seq_pkg::*;
(
  input  trig_e trig,
  input  logic  vsync_evt,
  input  logic  line_evt,
  input  logic  manual_kick,
  input  logic  idle,
  output logic  start
);
  logic hit;

  always_comb begin
    case (trig)
      TRG_VSYNC: hit = vsync_evt;
      TRG_LINE:  hit = line_evt;
      default:   hit = 1'b0;
    endcase
  end

  assign start = idle && (hit || manual_kick);
endmodule

// File: rtl/seq_engine.sv
module seq_engine
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          soft_rst,
  input  logic          stop_req,
  input  logic          clr_stat,
  input  logic [AW-1:0] list_begin,
  input  logic [AW-1:0] list_last,
  input  logic          wflag,
  input  logic          inc,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          reg_wr_valid,
  input  logic          reg_wr_ready,
  output logic [DW-1:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data,
  output logic          busy,
  output logic          done,
  output logic          err
);
  localparam int            IDXW       = DW - 2;
  localparam logic [AW-1:0] WORD_BYTES = AW'(4);
  localparam logic [AW-1:0] ONE_BYTE   = AW'(1);

  state_e          state_q, state_n;
  logic [AW-1:0]   ptr_q, ptr_n, last_q, last_n;
  logic [IDXW-1:0] idx_q, idx_n;
  logic [DW-1:0]   ea_q, ea_n, ed_q, ed_n;
  logic            inc_q, inc_n, stop_q, stop_n, done_q, done_n, err_q, err_n;
  logic [2:0]      tail;
  logic            bad, stop_eff;

  assign tail     = list_last[2:0] - list_begin[2:0];
  assign bad      = (list_last < list_begin) || (tail != 3'b111) || !wflag;
  assign stop_eff = stop_q || stop_req;

  always_comb begin
    state_n = state_q;
    ptr_n   = ptr_q;
    last_n  = last_q;
    idx_n   = idx_q;
    ea_n    = ea_q;
    ed_n    = ed_q;
    inc_n   = inc_q;
    stop_n  = stop_q;
    done_n  = done_q;
    err_n   = err_q;
    if (soft_rst) begin
      state_n = S_IDLE;
      stop_n  = 1'b0;
      done_n  = 1'b0;
      err_n   = 1'b0;
    end else begin
      if (clr_stat) begin
        done_n = 1'b0;
        err_n  = 1'b0;
      end
      if (stop_req && (state_q != S_IDLE)) stop_n = 1'b1;
      case (state_q)
        S_IDLE: begin
          stop_n = 1'b0;
          if (start) begin
            if (bad) begin
              err_n = 1'b1;
            end else begin
              state_n = S_REQ_A;
              ptr_n   = list_begin;
              last_n  = list_last;
              idx_n   = '0;
              inc_n   = inc;
            end
          end
        end
        S_REQ_A: if (mem_req_ready) state_n = S_WAIT_A;
        S_WAIT_A: if (mem_rsp_valid) begin
          ea_n    = mem_rsp_data;
          ptr_n   = ptr_q + WORD_BYTES;
          state_n = stop_eff ? S_IDLE : S_REQ_D;
        end
        S_REQ_D: if (mem_req_ready) state_n = S_WAIT_D;
        S_WAIT_D: if (mem_rsp_valid) begin
          ed_n    = mem_rsp_data;
          ptr_n   = ptr_q + WORD_BYTES;
          state_n = stop_eff ? S_IDLE : S_WRITE;
        end
        S_WRITE: if (reg_wr_ready) begin
          idx_n = idx_q + 1'b1;
          if (stop_eff) begin
            state_n = S_IDLE;
          end else if (ptr_q == last_q + ONE_BYTE) begin
            state_n = S_IDLE;
            done_n  = 1'b1;
          end else begin
            state_n = S_REQ_A;
          end
        end
        default: state_n = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ptr_q   <= '0;
      last_q  <= '0;
      idx_q   <= '0;
      ea_q    <= '0;
      ed_q    <= '0;
      inc_q   <= 1'b0;
      stop_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      ptr_q   <= ptr_n;
      last_q  <= last_n;
      idx_q   <= idx_n;
      ea_q    <= ea_n;
      ed_q    <= ed_n;
      inc_q   <= inc_n;
      stop_q  <= stop_n;
      done_q  <= done_n;
      err_q   <= err_n;
    end
  end

  assign mem_req_valid = (state_q == S_REQ_A) || (state_q == S_REQ_D);
  assign mem_req_addr  = ptr_q;
  assign reg_wr_valid  = (state_q == S_WRITE);
  assign reg_wr_addr   = inc_q ? (ea_q + {idx_q, 2'b00}) : ea_q;
  assign reg_wr_data   = ed_q;
  assign busy          = (state_q != S_IDLE);
  assign done          = done_q;
  assign err           = err_q;

  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_valid && !reg_wr_ready && !soft_rst |=>
      reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)); // R11
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready && !soft_rst |=> mem_req_valid && $stable(mem_req_addr)); // R11
  AST_DONE_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(reg_wr_valid && reg_wr_ready)); // R3
  AST_ERR_NO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> !busy && !reg_wr_valid && !mem_req_valid); // R8
  AST_STOP_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q && (state_q != S_IDLE) |=> !$rose(mem_req_valid)); // R6
  AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> !busy && !done_q && !err_q); // R10
endmodule

// File: rtl/evt_regwr_seq.sv
module evt_regwr_seq
  import seq_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [2:0]    cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [DW-1:0] cfg_rdata,
  input  logic          vsync_evt,
  input  logic          line_evt,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          reg_wr_valid,
  input  logic          reg_wr_ready,
  output logic [DW-1:0] reg_wr_addr,
  output logic [DW-1:0] reg_wr_data,
  output logic          irq
);
  logic [1:0]    rst_pipe;
  logic          rst_sync_n;
  logic [AW-1:0] list_begin, list_last;
  trig_e         trig;
  logic          wflag, inc, soft_rst, clr_stat, manual_kick, stop_req;
  logic          busy, done, err, start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  seq_csr #(.AW(AW), .DW(DW)) u_csr (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy), .done(done), .err(err),
    .list_begin(list_begin), .list_last(list_last), .trig(trig), .wflag(wflag), .inc(inc),
    .soft_rst(soft_rst), .clr_stat(clr_stat), .manual_kick(manual_kick), .stop_req(stop_req)
  );

  seq_trig u_trig (
    .trig(trig), .vsync_evt(vsync_evt), .line_evt(line_evt),
    .manual_kick(manual_kick), .idle(!busy), .start(start)
  );

  seq_engine #(.AW(AW), .DW(DW)) u_engine (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .soft_rst(soft_rst), .stop_req(stop_req),
    .clr_stat(clr_stat), .list_begin(list_begin), .list_last(list_last), .wflag(wflag), .inc(inc),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .busy(busy), .done(done), .err(err)
  );

  assign irq = done || err;
endmodule

// File: tb/evt_regwr_seq_test.sv
module evt_regwr_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = 3'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        vsync_evt = 1'b0, line_evt = 1'b0;
  logic        mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic        reg_wr_valid, reg_wr_ready = 1'b0;
  logic [31:0] reg_wr_addr, reg_wr_data;
  logic        irq;

  int checks = 0, errors = 0, memacc = 0, cyc = 0;
  int mr_mode = 0, wr_mode = 0, pass_left = 0;
  bit mon_en = 0, stop_mode = 0, err_kick = 0, m_irq = 0;
  logic [31:0] mem [0:127];
  logic [31:0] qa[$], qd[$];
  logic [31:0] ea, ed, rv;

  always #5 clk = !clk;

  evt_regwr_seq uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .vsync_evt(vsync_evt), .line_evt(line_evt),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .irq(irq)
  );

  // Memory and register-port responders: one-cycle read latency, selectable ready patterns.
  always @(posedge clk) begin
    cyc           <= cyc + 1;
    mem_rsp_valid <= mem_req_valid && mem_req_ready;
    mem_rsp_data  <= mem[mem_req_addr[8:2]];
    mem_req_ready <= (mr_mode == 0) ? 1'b1 : (cyc % 2 == 0);
    reg_wr_ready  <= (wr_mode == 0) ? 1'b1 : (wr_mode == 1) ? (cyc % 3 == 0) : 1'b0;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Reference model, compared on every falling edge.
  always @(negedge clk) if (mon_en) begin
    chk(irq === m_irq, "irq level R3 R8 R9", {31'b0, irq}, {31'b0, m_irq});
    if (reg_wr_valid && reg_wr_ready) begin
      if (qa.size() == 0) begin
        chk(1'b0, "R2 unexpected register write", reg_wr_addr, 32'h0);
      end else begin
        ea = qa.pop_front();
        ed = qd.pop_front();
        chk(reg_wr_addr == ea, "R2 R7 write address", reg_wr_addr, ea);
        chk(reg_wr_data == ed, "R2 write data", reg_wr_data, ed);
        if (pass_left > 0) begin
          pass_left--;
          if (pass_left == 0 && !stop_mode) m_irq = 1;
        end
      end
    end
    if (mem_req_valid && mem_req_ready) memacc++;
    if (cfg_we && cfg_addr == 3'd0 && (cfg_wdata[1] || cfg_wdata[0])) m_irq = 0;
    if (err_kick) m_irq = 1;
  end

  task automatic cfg_wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    cfg_addr = a; #1; d = cfg_rdata;
  endtask

  task automatic pulse(input bit vs, input bit ln, input bit bad);
    @(posedge clk); #1;
    vsync_evt = vs; line_evt = ln; err_kick = bad;
    @(posedge clk); #1;
    vsync_evt = 1'b0; line_evt = 1'b0; err_kick = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    logic [31:0] s;
    do begin
      @(negedge clk); #1;
      rd(3'd4, s);
      n++;
    end while (s[0] && n < 3000);
    @(posedge clk); #1;
  endtask

  task automatic put(input int base, input int k, input logic [31:0] a, input logic [31:0] d);
    mem[(base >> 2) + 2*k]     = a;
    mem[(base >> 2) + 2*k + 1] = d;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R5 actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'h0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk(!irq && !mem_req_valid && !reg_wr_valid, "R1 outputs idle", {29'b0, irq, mem_req_valid, reg_wr_valid}, 32'h0);
    rd(3'd4, rv); chk(rv == 32'h0, "R1 status", rv, 32'h0);
    rd(3'd3, rv); chk(rv == 32'h0, "R1 mode", rv, 32'h0);
    mon_en = 1;

    // R2 R3 R4: vertical-sync pass over three entries, plain addresses
    put(32'h040, 0, 32'h1000_0010, 32'hA5A5_0001);
    put(32'h040, 1, 32'h1000_0004, 32'h0000_BEEF);
    put(32'h040, 2, 32'h1000_0010, 32'h1234_5678);
    cfg_wr(3'd1, 32'h040); cfg_wr(3'd2, 32'h057); cfg_wr(3'd3, 32'h11);
    pulse(1'b0, 1'b1, 1'b0);
    repeat (3) @(posedge clk); #1;
    rd(3'd4, rv); chk(rv == 32'h0, "R4 unselected line event ignored", rv, 32'h0);
    qa.push_back(32'h1000_0010); qd.push_back(32'hA5A5_0001);
    qa.push_back(32'h1000_0004); qd.push_back(32'h0000_BEEF);
    qa.push_back(32'h1000_0010); qd.push_back(32'h1234_5678);
    pass_left = 3;
    pulse(1'b1, 1'b0, 1'b0);
    rd(3'd4, rv); chk(rv[0] == 1'b1, "R3 busy during pass", rv, 32'h1);
    wait_idle();
    chk(qa.size() == 0, "R2 all entries written", qa.size(), 0);
    rd(3'd4, rv); chk(rv == 32'h2, "R3 done status", rv, 32'h2);
    cfg_wr(3'd0, 32'h2);
    rd(3'd4, rv); chk(rv == 32'h0, "R9 status cleared", rv, 32'h0);

    // R4 R5 R7 R11: line trigger, increment mode, stalls on both ports
    mr_mode = 1; wr_mode = 1;
    for (int k = 0; k < 4; k++) put(32'h080, k, 32'h2000_0100, 32'hC0DE_0000 + k);
    cfg_wr(3'd1, 32'h080); cfg_wr(3'd2, 32'h09F); cfg_wr(3'd3, 32'h32);
    for (int k = 0; k < 4; k++) begin
      qa.push_back(32'h2000_0100 + 4*k); qd.push_back(32'hC0DE_0000 + k);
    end
    pass_left = 4;
    pulse(1'b0, 1'b1, 1'b0);
    repeat (3) @(posedge clk);
    pulse(1'b0, 1'b1, 1'b0);   // R5: arrives while busy, must be ignored
    wait_idle();
    repeat (20) @(posedge clk); #1;
    rd(3'd4, rv); chk(rv == 32'h2, "R5 retrigger while busy ignored", rv, 32'h2);
    chk(qa.size() == 0, "R7 increment writes", qa.size(), 0);
    cfg_wr(3'd0, 32'h2);
    for (int k = 0; k < 4; k++) begin
      qa.push_back(32'h2000_0100 + 4*k); qd.push_back(32'hC0DE_0000 + k);
    end
    pass_left = 4;
    pulse(1'b0, 1'b1, 1'b0);   // R5: still armed
    wait_idle();
    chk(qa.size() == 0, "R5 second pass complete", qa.size(), 0);
    cfg_wr(3'd0, 32'h2);
    mr_mode = 0; wr_mode = 0;

    // R4 manual start
    put(32'h0C0, 0, 32'h3000_0000, 32'h0000_0077);
    cfg_wr(3'd1, 32'h0C0); cfg_wr(3'd2, 32'h0C7);
    qa.push_back(32'h3000_0000); qd.push_back(32'h0000_0077);
    pass_left = 1;
    cfg_wr(3'd3, 32'h13);
    wait_idle();
    chk(qa.size() == 0, "R4 manual pass", qa.size(), 0);
    rd(3'd4, rv); chk(rv == 32'h2, "R4 manual done", rv, 32'h2);
    cfg_wr(3'd0, 32'h2);

    // R6 stop during a pass
    put(32'h100, 0, 32'h4000_0000, 32'h0000_0001);
    put(32'h100, 1, 32'h4000_0004, 32'h0000_0002);
    put(32'h100, 2, 32'h4000_0008, 32'h0000_0003);
    cfg_wr(3'd1, 32'h100); cfg_wr(3'd2, 32'h117); cfg_wr(3'd3, 32'h11);
    wr_mode = 2; stop_mode = 1; pass_left = 3;
    qa.push_back(32'h4000_0000); qd.push_back(32'h0000_0001);
    pulse(1'b1, 1'b0, 1'b0);
    begin
      int n = 0;
      while (!reg_wr_valid && n < 100) begin @(negedge clk); n++; end
    end
    chk(reg_wr_valid && reg_wr_addr == 32'h4000_0000, "R6 first write pending", reg_wr_addr, 32'h4000_0000);
    cfg_wr(3'd3, 32'h10);
    rv = memacc;
    wr_mode = 0;
    wait_idle();
    repeat (5) @(posedge clk); #1;
    chk(memacc == rv, "R6 no fetch after stop", memacc, rv);
    chk(qa.size() == 0, "R6 current write completed", qa.size(), 0);
    rd(3'd4, rv); chk(rv == 32'h0, "R6 no done after stop", rv, 32'h0);
    stop_mode = 0; pass_left = 0;

    // R8 malformed lists and cleared direction
    cfg_wr(3'd3, 32'h11);
    cfg_wr(3'd1, 32'h100); cfg_wr(3'd2, 32'h0FF);
    pulse(1'b1, 1'b0, 1'b1);
    #1 rd(3'd4, rv); chk(rv == 32'h4, "R8 last below first", rv, 32'h4);
    cfg_wr(3'd0, 32'h2);
    cfg_wr(3'd2, 32'h10B);
    pulse(1'b1, 1'b0, 1'b1);
    #1 rd(3'd4, rv); chk(rv == 32'h4, "R8 length not multiple of 8", rv, 32'h4);
    cfg_wr(3'd0, 32'h2);
    cfg_wr(3'd2, 32'h117); cfg_wr(3'd3, 32'h01);
    rv = memacc;
    pulse(1'b1, 1'b0, 1'b1);
    #1 rd(3'd4, rv); chk(rv == 32'h4, "R8 direction cleared", rv, 32'h4);
    chk(!reg_wr_valid && !mem_req_valid, "R8 no traffic", {30'b0, reg_wr_valid, mem_req_valid}, 32'h0);
    cfg_wr(3'd0, 32'h2);

    // R10 soft reset in the middle of a pass
    cfg_wr(3'd1, 32'h040); cfg_wr(3'd2, 32'h057); cfg_wr(3'd3, 32'h11);
    wr_mode = 2;
    qa.push_back(32'h1000_0010); qd.push_back(32'hA5A5_0001);
    pulse(1'b1, 1'b0, 1'b0);
    repeat (6) @(posedge clk);
    cfg_wr(3'd0, 32'h1);
    qa.delete(); qd.delete(); pass_left = 0;
    rd(3'd4, rv); chk(rv == 32'h0, "R10 engine idle", rv, 32'h0);
    rd(3'd3, rv); chk(rv[1:0] == 2'd0, "R10 trigger disarmed", rv, 32'h10);
    rd(3'd0, rv); chk(rv == 32'h0, "R10 control self-clears", rv, 32'h0);
    wr_mode = 0;
    pulse(1'b1, 1'b0, 1'b0);
    repeat (4) @(posedge clk); #1;
    rd(3'd4, rv); chk(rv == 32'h0, "R10 no pass after disarm", rv, 32'h0);

    repeat (3) @(posedge clk);
    mon_en = 0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule